// File: doc/BRIEF.md
# Timer Output Pin Controller

This block sits between one timer channel and its output pad. It holds the level that the pin shows, and it moves that level on pulses from the channel's counter and compare logic. In combination (PWM) mode a set pulse drives the pin to its active level and a clear pulse drives it to its idle level. A polarity bit picks which of high or low counts as active. In independent mode a toggle pulse flips the level and the polarity bit plays no part.

While the timer output path is disabled, software can preload the level register, so the pin starts from a known value. Once the timer output path is enabled, only channel events can move it. The pad driver is enabled one cycle after the port output enable is raised. Until then the pin floats, whatever the level and polarity settings are. A polarity change never moves the pin by itself. It only changes what the next set or clear pulse drives, so no glitch can appear.

Top module: `tmr_pin_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the level register is cleared to 0 and `pin_oe` goes to 0 after that edge.
- R2: After each rising edge with `rst_n` high, `pin_oe` equals the `port_oe` value sampled at that edge, so the pin floats (`pin_oe` = 0) until port output is enabled.
- R3: With `tmr_oe` = 0, a cycle with `sw_we` = 1 loads `sw_wdata` into the level, and `pin_o` shows it after the edge.
- R4: With `tmr_oe` = 1, `sw_we` has no effect on the level.
- R5: With `tmr_oe` = 0, the `set_ev`, `clr_ev` and `tgl_ev` pulses have no effect on the level.
- R6: With `tmr_oe` = 1 and `pwm_mode` = 1, a `set_ev` without `clr_ev` drives the active level: 1 when `pol_low` = 0 and 0 when `pol_low` = 1.
- R7: With `tmr_oe` = 1 and `pwm_mode` = 1, a `clr_ev` drives the idle level: 0 when `pol_low` = 0 and 1 when `pol_low` = 1.
- R8: When `set_ev` and `clr_ev` arrive in the same cycle in PWM mode, the clear action wins.
- R9: A change of `pol_low` in a cycle with no set, clear, toggle or write action leaves the level unchanged.
- R10: With `tmr_oe` = 1 and `pwm_mode` = 0, `tgl_ev` inverts the level whatever `pol_low` is, and `set_ev` and `clr_ev` have no effect.
- R11: With `tmr_oe` = 1 and `pwm_mode` = 1, `tgl_ev` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_ev | input | 1 | Set pulse from the channel |
| clr_ev | input | 1 | Clear pulse from the channel |
| tgl_ev | input | 1 | Toggle pulse from the channel |
| pwm_mode | input | 1 | 1 = combination (PWM) mode, 0 = independent mode |
| pol_low | input | 1 | 1 = active low, 0 = active high (PWM mode only) |
| tmr_oe | input | 1 | 1 = channel events own the level, 0 = software owns it |
| sw_we | input | 1 | Software write strobe for the level register |
| sw_wdata | input | 1 | Software write data |
| port_oe | input | 1 | Port output enable |
| pin_o | output | 1 | Pin level (the level register) |
| pin_oe | output | 1 | Pad drive enable; 0 = high impedance |

## Verification
A wrong level register shows up at once on `pin_o`, one edge after the offending cycle. It then stays wrong until the next action that loads an absolute value: a software write, or a set or clear pulse. A toggle only carries the error forward, so a bad decode in independent mode can stay hidden until software reloads the level. The bench therefore compares the pin on every cycle, not only after events. A wrong enable shows on `pin_oe` one edge after the change in `port_oe`.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_TO_ACTIVE,
        ACT_TO_IDLE,
        ACT_FLIP
    } tpc_act_e;

    typedef struct packed {
        logic level;
    } tpc_level_t;

    typedef struct packed {
        logic drive;
    } tpc_gate_t;

endpackage

// File: rtl/tpc_event_decode.sv
module tpc_event_decode
    import tpc_pkg::*;
(
    input  logic     set_ev,
    input  logic     clr_ev,
    input  logic     tgl_ev,
    input  logic     pwm_mode,
    input  logic     tmr_oe,
    input  logic     sw_we,
    output tpc_act_e act
);

    always_comb begin
        act = ACT_HOLD;
        if (!tmr_oe) begin
            // software owns the level; channel pulses are dropped
            if (sw_we) act = ACT_LOAD;
        end else if (pwm_mode) begin
            // clear has priority over set
            if (clr_ev)      act = ACT_TO_IDLE;
            else if (set_ev) act = ACT_TO_ACTIVE;
        end else begin
            if (tgl_ev) act = ACT_FLIP;
        end
    end

endmodule

// File: rtl/tpc_level_reg.sv
module tpc_level_reg
    import tpc_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tpc_act_e act,
    input  logic     pol_low,
    input  logic     sw_wdata,
    output logic     level
);

    tpc_level_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD:      st_d.level = sw_wdata;
            ACT_TO_ACTIVE: st_d.level = ~pol_low;
            ACT_TO_IDLE:   st_d.level = pol_low;
            ACT_FLIP:      st_d.level = ~st_q.level;
            default:       st_d.level = st_q.level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{level: RST_LEVEL};
        else        st_q <= st_d;
    end

    assign level = st_q.level;

    assert_hold_keeps_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HOLD) |=> $stable(level));

    assert_active_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_TO_ACTIVE) |=> (level == !$past(pol_low)));

    assert_idle_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_TO_IDLE) |=> (level == $past(pol_low)));

    assert_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_FLIP) |=> (level != $past(level)));

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LOAD) |=> (level == $past(sw_wdata)));

endmodule

// File: rtl/tpc_pin_gate.sv
module tpc_pin_gate
    import tpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_oe,
    output logic pin_oe
);

    tpc_gate_t gt_d, gt_q;

    always_comb begin
        gt_d       = gt_q;
        gt_d.drive = port_oe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gt_q <= '{drive: 1'b0};
        else        gt_q <= gt_d;
    end

    assign pin_oe = gt_q.drive;

    assert_float_until_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !port_oe |=> !pin_oe);

endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
    import tpc_pkg::*;
#(
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic tgl_ev,
    input  logic pwm_mode,
    input  logic pol_low,
    input  logic tmr_oe,
    input  logic sw_we,
    input  logic sw_wdata,
    input  logic port_oe,
    output logic pin_o,
    output logic pin_oe
);

    tpc_act_e act;
    logic     level;

    tpc_event_decode u_decode (
        .set_ev   (set_ev),
        .clr_ev   (clr_ev),
        .tgl_ev   (tgl_ev),
        .pwm_mode (pwm_mode),
        .tmr_oe   (tmr_oe),
        .sw_we    (sw_we),
        .act      (act)
    );

    tpc_level_reg #(.RST_LEVEL(RST_LEVEL)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .pol_low  (pol_low),
        .sw_wdata (sw_wdata),
        .level    (level)
    );

    tpc_pin_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_oe (port_oe),
        .pin_oe  (pin_oe)
    );

    assign pin_o = level;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == 1'b0 && pin_o == RST_LEVEL));

    assert_sw_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_oe && !set_ev && !clr_ev && !tgl_ev) |=> $stable(pin_o));

    assert_events_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_oe && !sw_we) |=> $stable(pin_o));

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_oe && pwm_mode && set_ev && clr_ev) |=> (pin_o == $past(pol_low)));

    assert_toggle_ignored_pwm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_oe && pwm_mode && !set_ev && !clr_ev) |=> $stable(pin_o));

endmodule

// File: tb/test_tmr_pin_ctrl.sv
module test_tmr_pin_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_ev = 0, clr_ev = 0, tgl_ev = 0, pwm_mode = 0, pol_low = 0;
    logic tmr_oe = 0, sw_we = 0, sw_wdata = 0, port_oe = 0;
    logic pin_o, pin_oe;

    int   n_checks = 0;
    int   n_errors = 0;
    logic exp_level = 1'b0;
    logic exp_oe = 1'b0;

    always #5 clk = ~clk;

    tmr_pin_ctrl i_tmr_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev), .tgl_ev(tgl_ev),
        .pwm_mode(pwm_mode), .pol_low(pol_low), .tmr_oe(tmr_oe), .sw_we(sw_we),
        .sw_wdata(sw_wdata), .port_oe(port_oe), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    // expected level from the requirements
    function automatic logic next_level(logic cur, logic r, logic s, logic c, logic t,
                                        logic pm, logic pl, logic oe, logic we, logic wd);
        if (!r) return 1'b0;                 // R1
        if (!oe) return we ? wd : cur;       // R3, R5
        if (pm) begin
            if (c) return pl;                // R7, R8
            if (s) return ~pl;               // R6
            return cur;                      // R4, R9, R11
        end
        return t ? ~cur : cur;               // R10
    endfunction

    function automatic string tag_of(logic r, logic s, logic c, logic t,
                                     logic pm, logic oe, logic we);
        if (!r) return "R1";
        if (!oe) return we ? "R3" : "R5";
        if (pm) begin
            if (s && c) return "R8";
            if (c) return "R7";
            if (s) return "R6";
            if (t) return "R11";
            if (we) return "R4";
            return "R9";
        end
        return "R10";
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic step(logic r, logic s, logic c, logic t, logic pm, logic pl,
                        logic oe, logic we, logic wd, logic po);
        string tg;
        rst_n = r; set_ev = s; clr_ev = c; tgl_ev = t; pwm_mode = pm; pol_low = pl;
        tmr_oe = oe; sw_we = we; sw_wdata = wd; port_oe = po;
        tg = tag_of(r, s, c, t, pm, oe, we);
        @(posedge clk);
        exp_level = next_level(exp_level, r, s, c, t, pm, pl, oe, we, wd);
        exp_oe    = r ? po : 1'b0;
        @(negedge clk);
        check(tg, "pin_o", pin_o, exp_level);
        check(r ? "R2" : "R1", "pin_oe", pin_oe, exp_oe);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        n_checks++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1d2c);
        @(negedge clk);
        // R1 reset state
        step(0, 1, 0, 1, 1, 0, 1, 1, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3 preload with output path off, pin floating (R2)
        step(1, 0, 0, 0, 1, 0, 0, 1, 1, 0);
        // R5 events ignored while tmr_oe=0
        step(1, 0, 1, 1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, 1);
        // R4 write ignored once tmr_oe=1
        step(1, 0, 0, 0, 1, 0, 1, 1, 0, 1);
        // R7 clear, active high
        step(1, 0, 1, 0, 1, 0, 1, 0, 0, 1);
        // R9 polarity flip does not move the pin
        step(1, 0, 0, 0, 1, 1, 1, 0, 0, 1);
        // R6 set with active low drives 0
        step(1, 1, 0, 0, 1, 1, 1, 0, 0, 1);
        // R7 clear with active low drives 1
        step(1, 0, 1, 0, 1, 1, 1, 0, 0, 1);
        // R8 simultaneous set and clear, active high: idle 0
        step(1, 1, 1, 0, 1, 0, 1, 0, 0, 1);
        // R11 toggle ignored in PWM mode
        step(1, 0, 0, 1, 1, 0, 1, 0, 0, 1);
        // R10 toggle in independent mode, polarity irrelevant, set/clear ignored
        step(1, 0, 0, 1, 0, 1, 1, 0, 0, 1);
        step(1, 1, 1, 0, 0, 0, 1, 0, 0, 1);
        step(1, 0, 0, 1, 0, 0, 1, 0, 0, 1);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic r;
            r = ($urandom % 64) != 0;
            step(r, ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
                 ($urandom % 3) != 0, ($urandom % 6) == 0, ($urandom % 4) != 0,
                 ($urandom % 4) == 0, 1'($urandom), ($urandom % 8) != 0);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule